// File: doc/BRIEF.md
# Profiling Cycle Counters with Overflow Events

This block keeps five 8-bit profiling counters, one for each class of processor cycle: cycles beyond the first of a multi-cycle instruction, exception entry and exit overhead cycles, sleep cycles, load/store cycles after an instruction's first cycle, and instructions that retire in zero cycles (folded). Each cycle, the core drives one qualifier strobe per class. The core is responsible for the counting rule of each class. For example, it never raises the load/store strobe on an instruction's first cycle, and it keeps multi-cycle extra cycles apart from load/store extra cycles. The block adds one to each counter whose strobe is high.

Every counter wraps silently from 255 to 0. On the wrap it raises a one-cycle event pulse, but only if that counter's enable bit is set in the control word. Several counters can wrap in the same cycle. The pulses come out as a parallel vector, so none is lost and none takes priority. The control word also holds an exception-trace enable, which is exported as a level.

A small register port gives access to the control word and to the five counters. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `prof_evt_counters`

## Requirements
- R1: Strobe and event index i maps to a class: 0 multi-cycle extra, 1 exception overhead, 2 sleep, 3 load/store extra, 4 folded. Counter i is at register address 1+i and reads in bits 7:0 with upper bits zero. It adds exactly one on each clock edge where strobe i is high, and holds otherwise.
- R2: A counter at 255 that is incremented becomes 0 and keeps counting, whether or not its event is enabled.
- R3: Event bit i is high for exactly the one cycle after the edge on which counter i wrapped from 255 to 0. It is raised only if control bit 17+i was set before that edge. It is never high otherwise.
- R4: Counters that wrap on the same edge all raise their event bits together in the same cycle.
- R5: A register write to counter i loads the written value, even when strobe i is high on the same edge. Such a write produces no event.
- R6: The control word is at address 0. Bits 21 down to 17 are the event enables for index 4 down to 0. Bit 16 is the exception-trace enable. These bits read back as written and hold when not written.
- R7: All other control bits, including reserved bits 15:13, read as zero and ignore writes. For example, writing all ones reads back 0x003F0000.
- R8: The exception-trace output equals control bit 16, starting from the edge of the write.
- R9: Synchronous active-high reset clears the control word and all counters, and no events are high after reset.
- R10: Addresses 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_inc_i | input | 5 | Per-class increment strobes, index as in R1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 control, 1 to 5 counters |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| evt_o | output | 5 | Overflow event pulses, index as in R1 |
| exc_trace_en_o | output | 1 | Exception-trace enable level |

## Verification
The bench builds the block with its default parameters: five 8-bit counters and a 32-bit register word. With these values a wrap is reached by presetting a counter near 255 through the write port, then strobing it. The bench aligns all five counters at 255 to force simultaneous wraps. It also collides writes with increments on the wrap edge. A long random phase then mixes strobes, enables and writes to every address, including the unused ones.

// File: rtl/prof_pkg.sv
`timescale 1ns/1ps
package prof_pkg;
    localparam int NUM_CLS   = 5;
    localparam int CNT_BITS  = 8;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int EN_LSB    = 17;
    localparam int TRC_BIT   = 16;
    localparam int CTRL_ADDR = 0;
    localparam int CNT_BASE  = 1;

    typedef enum logic [2:0] {
        CLS_MULTI = 3'd0,
        CLS_EXC   = 3'd1,
        CLS_SLEEP = 3'd2,
        CLS_LSU   = 3'd3,
        CLS_FOLD  = 3'd4
    } cls_e;

    typedef struct packed {
        logic [NUM_CLS-1:0] evt_en;
        logic               trace_en;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] ctrl_to_word(ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_LSB +: NUM_CLS] = c.evt_en;
        w[TRC_BIT]           = c.trace_en;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.evt_en   = w[EN_LSB +: NUM_CLS];
        c.trace_en = w[TRC_BIT];
        return c;
    endfunction
endpackage

// File: rtl/prof_ctrl_reg.sv
`timescale 1ns/1ps
module prof_ctrl_reg
    import prof_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [NUM_CLS-1:0] en_o,
    output logic               trace_o,
    output logic [WORD_W-1:0]  rdata_o
);
    ctrl_t ctrl_q;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata_i[WORD_W-1:EN_LSB+NUM_CLS], wdata_i[TRC_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= word_to_ctrl(wdata_i);
        end
    end

    assign en_o    = ctrl_q.evt_en;
    assign trace_o = ctrl_q.trace_en;
    assign rdata_o = ctrl_to_word(ctrl_q);

    assert_trace_R8: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (trace_o == $past(wdata_i[TRC_BIT])));

    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(en_o) && $stable(trace_o)));
endmodule

// File: rtl/prof_counter.sv
`timescale 1ns/1ps
module prof_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             evt_q;
    logic             wrap;

    always_comb begin
        wrap = inc_i && !wr_i && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= wrap && en_i;
            if (wr_i) begin
                cnt_q <= wdata_i;
            end else if (inc_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign evt_o = evt_q;

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !wr_i) |=> $stable(cnt_o));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !wr_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));

    assert_evt_on_R3: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !wr_i && cnt_o == CNT_MAX && en_i) |=> evt_o);

    assert_evt_off_R3: assert property (@(posedge clk) disable iff (rst)
        !(inc_i && !wr_i && cnt_o == CNT_MAX && en_i) |=> !evt_o);

    assert_write_wins_R5: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((cnt_o == $past(wdata_i)) && !evt_o));
endmodule

// File: rtl/prof_evt_counters.sv
`timescale 1ns/1ps
module prof_evt_counters
    import prof_pkg::*;
#(
    parameter int NUM_CNT = NUM_CLS,
    parameter int CNT_W   = CNT_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] cls_inc_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [WORD_W-1:0]  reg_wdata_i,
    output logic [WORD_W-1:0]  reg_rdata_o,
    output logic [NUM_CNT-1:0] evt_o,
    output logic               exc_trace_en_o
);
    localparam int PAD_W = WORD_W - CNT_W;

    logic                 ctrl_wr;
    logic [NUM_CLS-1:0]   evt_en;
    logic [WORD_W-1:0]    ctrl_rdata;
    logic [NUM_CNT-1:0]   cnt_wr;
    logic [CNT_W-1:0]     cnt_val [NUM_CNT];

    assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));

    prof_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctrl_wr),
        .wdata_i (reg_wdata_i),
        .en_o    (evt_en),
        .trace_o (exc_trace_en_o),
        .rdata_o (ctrl_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign cnt_wr[i] = reg_wr_i && (reg_addr_i == ADDR_W'(CNT_BASE + i));

        prof_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (cls_inc_i[i]),
            .wr_i    (cnt_wr[i]),
            .wdata_i (reg_wdata_i[CNT_W-1:0]),
            .en_i    (evt_en[i]),
            .cnt_o   (cnt_val[i]),
            .evt_o   (evt_o[i])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata_o = ctrl_rdata;
        end
        for (int k = 0; k < NUM_CNT; k++) begin
            if (reg_addr_i == ADDR_W'(CNT_BASE + k)) begin
                reg_rdata_o = {{PAD_W{1'b0}}, cnt_val[k]};
            end
        end
    end

    assert_ctrl_rsv_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == ADDR_W'(CTRL_ADDR)) |->
            (reg_rdata_o[TRC_BIT-1:0] == '0 && reg_rdata_o[WORD_W-1:EN_LSB+NUM_CLS] == '0));

    assert_trace_lvl_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == ADDR_W'(CTRL_ADDR)) |-> (reg_rdata_o[TRC_BIT] == exc_trace_en_o));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i > ADDR_W'(NUM_CNT)) |-> (reg_rdata_o == '0));
endmodule

// File: tb/sim_prof_evt_counters.sv
`timescale 1ns/1ps
module sim_prof_evt_counters;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cls_inc_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [4:0]  evt_o;
    logic        exc_trace_en_o;

    int checks = 0;
    int errors = 0;

    int   cnt_m [5];
    bit   en_m  [5];
    bit   trc_m;
    logic [4:0] evt_m;

    always #4 clk = ~clk;

    prof_evt_counters u0 (
        .clk(clk), .rst(rst), .cls_inc_i(cls_inc_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .evt_o(evt_o), .exc_trace_en_o(exc_trace_en_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 0) begin
            for (int i = 0; i < 5; i++) r[17+i] = en_m[i];
            r[16] = trc_m;
        end else if (a <= 5) begin
            r = cnt_m[a-1];
        end
        return r;
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        if (a == 0) return "R6";
        if (a <= 5) return "R1";
        return "R10";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            cnt_m[i] = 0;
            en_m[i]  = 0;
        end
        trc_m = 0;
        evt_m = '0;
    endtask

    task automatic cyc(input logic [4:0] inc, input bit wr, input logic [2:0] a,
                       input logic [31:0] wd);
        cls_inc_i   = inc;
        reg_wr_i    = wr;
        reg_addr_i  = a;
        reg_wdata_i = wd;
        @(posedge clk);
        for (int i = 0; i < 5; i++) begin
            bit hit;
            hit = wr && (a == 3'(i + 1));
            evt_m[i] = inc[i] && !hit && (cnt_m[i] == 255) && en_m[i];
            if (hit) cnt_m[i] = int'(wd[7:0]);
            else if (inc[i]) cnt_m[i] = (cnt_m[i] + 1) % 256;
        end
        if (wr && a == 0) begin
            for (int i = 0; i < 5; i++) en_m[i] = wd[17+i];
            trc_m = wd[16];
        end
        @(negedge clk);
        chk({27'd0, evt_o}, {27'd0, evt_m}, "R3");
        chk({31'd0, exc_trace_en_o}, {31'd0, trc_m}, "R8");
        chk(reg_rdata_o, model_read(a), read_tag(a));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(5'd0, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic read_at(input logic [2:0] a, input logic [31:0] exp, input string tag);
        cyc(5'd0, 1'b0, a, 32'd0);
        chk(reg_rdata_o, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: state after reset
        for (int a = 0; a < 8; a++) read_at(3'(a), 32'd0, "R9");
        chk({27'd0, evt_o}, 32'd0, "R9");

        // R7: reserved and undefined control bits read zero
        cyc(5'd0, 1'b1, 3'd0, 32'hFFFF_FFFF);
        read_at(3'd0, 32'h003F_0000, "R7");
        chk({31'd0, exc_trace_en_o}, 32'd1, "R8");

        // R1: counting on each class
        for (int i = 0; i < 5; i++) begin
            for (int k = 0; k <= i; k++) cyc(5'(1 << i), 1'b0, 3'(i + 1), 32'd0);
            read_at(3'(i + 1), 32'(i + 1), "R1");
        end

        // R3/R4: all five wrap together, all enabled
        for (int i = 0; i < 5; i++) cyc(5'd0, 1'b1, 3'(i + 1), 32'd255);
        cyc(5'h1F, 1'b0, 3'd1, 32'd0);
        chk({27'd0, evt_o}, 32'h1F, "R4");
        cyc(5'd0, 1'b0, 3'd1, 32'd0);
        chk({27'd0, evt_o}, 32'd0, "R3");

        // R2: disabled counter wraps silently and keeps counting
        cyc(5'd0, 1'b1, 3'd0, 32'h0001_0000);
        cyc(5'd0, 1'b1, 3'd3, 32'd254);
        for (int k = 0; k < 3; k++) begin
            cyc(5'b00100, 1'b0, 3'd3, 32'd0);
            chk({27'd0, evt_o}, 32'd0, "R2");
        end
        read_at(3'd3, 32'd1, "R2");

        // R3: only the enabled wrap raises its bit
        cyc(5'd0, 1'b1, 3'd0, 32'h0010_0000);
        for (int i = 0; i < 5; i++) cyc(5'd0, 1'b1, 3'(i + 1), 32'd255);
        cyc(5'h1F, 1'b0, 3'd0, 32'd0);
        chk({27'd0, evt_o}, 32'h08, "R3");

        // R5: write collides with wrap increment
        cyc(5'd0, 1'b1, 3'd0, 32'h003E_0000);
        cyc(5'd0, 1'b1, 3'd2, 32'd255);
        cyc(5'b00010, 1'b1, 3'd2, 32'h0000_0010);
        chk({27'd0, evt_o}, 32'd0, "R5");
        read_at(3'd2, 32'h10, "R5");

        // R10: unmapped writes change nothing
        cyc(5'd0, 1'b1, 3'd6, 32'hFFFF_FFFF);
        cyc(5'd0, 1'b1, 3'd7, 32'hFFFF_FFFF);
        read_at(3'd6, 32'd0, "R10");
        read_at(3'd0, 32'h003E_0000, "R10");
        read_at(3'd2, 32'h10, "R10");

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0)
                cyc(5'($urandom), 1'b1, 3'(r[6:4]), (r[7] ? 32'd255 : 32'd250) | ($urandom & 32'h003F_0000));
            else
                cyc(5'($urandom), 1'b0, 3'(r[6:4]), 32'd0);
        end

        // R9: reset mid-run clears everything
        cls_inc_i = '0; reg_wr_i = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int a = 0; a < 6; a++) read_at(3'(a), 32'd0, "R9");

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule